// File: doc/BRIEF.md
# Masked Multi-Channel Identifier Filter

This block decides which of a set of programmable receive channels takes an incoming frame. Once the serial receiver has finished collecting a 12-bit frame identifier, it pulses a strobe. The filter then compares the identifier against every channel's tag under that channel's per-bit mask. The lowest-numbered eligible channel that matches wins. The block reports the winner's index and its buffer pointer. When the winning channel's pointer is zero, the channel borrows the buffer of another channel named in its link field. Only one level of linking is resolved.

When the receiver later reports how many data bytes arrived, the filter turns the winner's reserved length into two results: the number of data bytes to store, and whether the two CRC bytes also fit. All channel settings live in a byte-wide register file. Channel k begins at byte address 0x10 + 8*k. Channel storage has no reset, so software writes every byte before it enables a channel. A channel's received flag is set only by the filter. Software can only clear it.

Top module: `id_filter`

## Requirements
- R1: Channel k (0..13) occupies bytes 0x10+8k..0x17+8k, laid out as follows:
  - +0: tag[7:0]
  - +1: tag[11:8] in bits 3:0
  - +2: mask[7:0]
  - +3: mask[11:8] in bits 3:0
  - +4: pointer in bits 6:0
  - +5: enable in bit 7 and reserved length in bits 4:0
  - +6: received flag in bit 0
  - +7: link target in bits 3:0

  Every other bit reads as 0. Addresses outside the channel area read as 0.
- R2: A mask bit of 1 requires the identifier bit to equal the tag bit. A mask bit of 0 ignores that identifier bit.
- R3: When several eligible channels match, the lowest-numbered one is reported.
- R4: A channel is eligible only while its enable bit is 1 and its received flag is 0.
- R5: On the clock edge that samples `id_done`, exactly one of `hit_valid` or `hit_none` is raised, for one cycle. With `hit_valid` the block also presents `hit_chan`.
- R6: The winning channel's received flag is set by the same edge. A software write of 0 to bit 0 of byte +6 clears the flag. A write of 1 to that bit has no effect.
- R7: A winner with a nonzero pointer reports that pointer on `hit_ptr`. A winner with pointer 0 is a link. It reports the pointer of its link target, provided the target index is below 14 and the target's own pointer is nonzero. Otherwise the block raises `hit_badlink` and reports pointer 0.
- R8: One edge after `len_done`, `len_report` equals `len_rcvd`. `len_store` equals the smaller of `len_rcvd` and the winner's reserved length.
- R9: `crc_keep` is 1 exactly when the reserved length is at least `len_rcvd` + 2.
- R10: `len_valid` pulses one edge after `len_done` only when the latest identifier result was a hit that no earlier `len_done` has consumed. Otherwise `len_valid`, `len_report`, `len_store` and `crc_keep` stay 0.
- R11: During reset all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low (result outputs only) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| id_done | input | 1 | Identifier complete strobe |
| id_in | input | 12 | Received identifier |
| hit_valid | output | 1 | A channel took the frame |
| hit_none | output | 1 | No eligible channel matched |
| hit_chan | output | 4 | Winning channel index |
| hit_ptr | output | 7 | Resolved buffer pointer |
| hit_badlink | output | 1 | Winner's link could not be resolved |
| len_done | input | 1 | Data field complete strobe |
| len_rcvd | input | 5 | Data bytes received |
| len_valid | output | 1 | Length results present |
| len_report | output | 5 | Received length as reported |
| len_store | output | 5 | Data bytes to store |
| crc_keep | output | 1 | CRC bytes are stored after the data |

## Verification
The match result is registered once, so `hit_*` is due on the edge that samples `id_done`. The length results follow the same rule, one edge after `len_done`. The bench raises each strobe just after a falling edge and drops it at the next falling edge. It reads the results at that second falling edge, half a period after the due edge and before the one-cycle pulse ends. Register reads are combinational, so they are sampled a short delay after the address is set. The received flag's hardware set and software clear are checked through the next identifier's result and through a read of byte +6.

// File: rtl/idflt_pkg.sv
`timescale 1ns/1ps
package idflt_pkg;
   localparam logic [2:0] OFS_TAG_LO  = 3'd0;
   localparam logic [2:0] OFS_TAG_HI  = 3'd1;
   localparam logic [2:0] OFS_MSK_LO  = 3'd2;
   localparam logic [2:0] OFS_MSK_HI  = 3'd3;
   localparam logic [2:0] OFS_PTR     = 3'd4;
   localparam logic [2:0] OFS_CTL     = 3'd5;
   localparam logic [2:0] OFS_STAT    = 3'd6;
   localparam logic [2:0] OFS_LINK    = 3'd7;
   localparam int         CTL_EN_BIT  = 7;
endpackage

// File: rtl/idflt_chan.sv
`timescale 1ns/1ps
module idflt_chan
   import idflt_pkg::*;
#(
   parameter int ID_W   = 12,
   parameter int PTR_W  = 7,
   parameter int LEN_W  = 5,
   parameter int LINK_W = 4
)(
   input  logic              clk,
   input  logic              wr,
   input  logic [2:0]        ofs,
   input  logic [7:0]        wdata,
   input  logic              hw_set,
   output logic [ID_W-1:0]   tag,
   output logic [ID_W-1:0]   mask,
   output logic [PTR_W-1:0]  ptr,
   output logic              en,
   output logic [LEN_W-1:0]  rsv,
   output logic              rxf,
   output logic [LINK_W-1:0] link,
   output logic [7:0]        rdata
);
   // channel storage is deliberately not reset
   always_ff @(posedge clk) begin
      if (wr) begin
         case (ofs)
            OFS_TAG_LO: tag[7:0]       <= wdata;
            OFS_TAG_HI: tag[ID_W-1:8]  <= wdata[ID_W-9:0];
            OFS_MSK_LO: mask[7:0]      <= wdata;
            OFS_MSK_HI: mask[ID_W-1:8] <= wdata[ID_W-9:0];
            OFS_PTR:    ptr            <= wdata[PTR_W-1:0];
            OFS_CTL: begin
               en  <= wdata[CTL_EN_BIT];
               rsv <= wdata[LEN_W-1:0];
            end
            OFS_LINK:   link           <= wdata[LINK_W-1:0];
            default: ;
         endcase
      end
   end

   // received flag: hardware sets, software may only clear
   always_ff @(posedge clk) begin
      if (hw_set)
         rxf <= 1'b1;
      else if (wr && ofs == OFS_STAT && !wdata[0])
         rxf <= 1'b0;
   end

   always_comb begin
      rdata = 8'h00;
      case (ofs)
         OFS_TAG_LO: rdata = tag[7:0];
         OFS_TAG_HI: rdata = 8'(tag >> 8);
         OFS_MSK_LO: rdata = mask[7:0];
         OFS_MSK_HI: rdata = 8'(mask >> 8);
         OFS_PTR:    rdata = 8'(ptr);
         OFS_CTL: begin
            rdata             = 8'(rsv);
            rdata[CTL_EN_BIT] = en;
         end
         OFS_STAT:   rdata = {7'b0, rxf};
         OFS_LINK:   rdata = 8'(link);
         default:    rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/idflt_match.sv
`timescale 1ns/1ps
module idflt_match #(
   parameter int N_CH = 14,
   parameter int ID_W = 12,
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
)(
   input  logic [ID_W-1:0] id,
   input  logic [ID_W-1:0] tag  [N_CH],
   input  logic [ID_W-1:0] mask [N_CH],
   input  logic [N_CH-1:0] elig,
   output logic            any,
   output logic [CH_W-1:0] win
);
   logic [N_CH-1:0] cand;

   for (genvar k = 0; k < N_CH; k++) begin : g_cmp
      assign cand[k] = elig[k] && (((id ^ tag[k]) & mask[k]) == '0);
   end

   // lowest index has priority: scan downward so it is written last
   always_comb begin
      win = '0;
      for (int k = N_CH - 1; k >= 0; k--) begin
         if (cand[k]) win = CH_W'(k);
      end
   end

   assign any = |cand;
endmodule

// File: rtl/idflt_len.sv
`timescale 1ns/1ps
module idflt_len #(
   parameter int LEN_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             len_done,
   input  logic             armed,
   input  logic [LEN_W-1:0] rcv,
   input  logic [LEN_W-1:0] rsv,
   output logic             len_valid,
   output logic [LEN_W-1:0] len_report,
   output logic [LEN_W-1:0] len_store,
   output logic             crc_keep
);
   logic             go;
   logic [LEN_W:0]   need_crc;
   logic [LEN_W-1:0] fit;

   assign go       = len_done && armed;
   assign need_crc = {1'b0, rcv} + (LEN_W+1)'(2);
   assign fit      = (rsv < rcv) ? rsv : rcv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_valid  <= 1'b0;
         len_report <= '0;
         len_store  <= '0;
         crc_keep   <= 1'b0;
      end else begin
         len_valid  <= go;
         len_report <= go ? rcv : '0;
         len_store  <= go ? fit : '0;
         crc_keep   <= go && ({1'b0, rsv} >= need_crc);
      end
   end
endmodule

// File: rtl/id_filter.sv
`timescale 1ns/1ps
module id_filter #(
   parameter int N_CH   = 14,
   parameter int ID_W   = 12,
   parameter int PTR_W  = 7,
   parameter int LEN_W  = 5,
   parameter int ADDR_W = 8,
   parameter int BASE   = 'h10,
   localparam int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              id_done,
   input  logic [ID_W-1:0]   id_in,
   output logic              hit_valid,
   output logic              hit_none,
   output logic [CH_W-1:0]   hit_chan,
   output logic [PTR_W-1:0]  hit_ptr,
   output logic              hit_badlink,
   input  logic              len_done,
   input  logic [LEN_W-1:0]  len_rcvd,
   output logic              len_valid,
   output logic [LEN_W-1:0]  len_report,
   output logic [LEN_W-1:0]  len_store,
   output logic              crc_keep
);
   localparam int STRIDE = 8;
   localparam int SPAN   = STRIDE * N_CH;
   localparam int SEL_W  = ADDR_W - 3;

   if (N_CH < 1 || N_CH > 16) begin : g_bad_nch
      $error("id_filter: N_CH must be 1..16");
   end
   if (ID_W < 9 || ID_W > 16) begin : g_bad_idw
      $error("id_filter: ID_W must be 9..16");
   end
   if (PTR_W < 1 || PTR_W > 8 || LEN_W < 1 || LEN_W > 7) begin : g_bad_fld
      $error("id_filter: PTR_W or LEN_W out of range");
   end
   if (BASE % STRIDE != 0 || BASE + SPAN > (1 << ADDR_W)) begin : g_bad_map
      $error("id_filter: register window does not fit the address space");
   end

   // ---------------- register file ----------------
   logic [ADDR_W-1:0] off;
   logic              in_win;
   logic [SEL_W-1:0]  sel;

   assign off    = reg_addr - ADDR_W'(BASE);
   assign in_win = (int'(reg_addr) >= BASE) && (int'(off) < SPAN);
   assign sel    = off[ADDR_W-1:3];

   logic [ID_W-1:0]  tag  [N_CH];
   logic [ID_W-1:0]  mask [N_CH];
   logic [PTR_W-1:0] ptr  [N_CH];
   logic [LEN_W-1:0] rsv  [N_CH];
   logic [CH_W-1:0]  link [N_CH];
   logic [7:0]       crd  [N_CH];
   logic [N_CH-1:0]  en, rxf, hw_set, elig;

   logic             any;
   logic [CH_W-1:0]  win;

   for (genvar k = 0; k < N_CH; k++) begin : g_ch
      idflt_chan #(
         .ID_W(ID_W), .PTR_W(PTR_W), .LEN_W(LEN_W), .LINK_W(CH_W)
      ) u_chan (
         .clk   (clk),
         .wr    (reg_wr && in_win && sel == SEL_W'(k)),
         .ofs   (off[2:0]),
         .wdata (reg_wdata),
         .hw_set(hw_set[k]),
         .tag   (tag[k]),
         .mask  (mask[k]),
         .ptr   (ptr[k]),
         .en    (en[k]),
         .rsv   (rsv[k]),
         .rxf   (rxf[k]),
         .link  (link[k]),
         .rdata (crd[k])
      );
      assign elig[k]   = en[k] && !rxf[k];
      assign hw_set[k] = id_done && any && win == CH_W'(k);
   end

   always_comb begin
      reg_rdata = 8'h00;
      for (int k = 0; k < N_CH; k++) begin
         if (in_win && sel == SEL_W'(k)) reg_rdata = crd[k];
      end
   end

   // ---------------- match and link ----------------
   idflt_match #(.N_CH(N_CH), .ID_W(ID_W)) u_match (
      .id  (id_in),
      .tag (tag),
      .mask(mask),
      .elig(elig),
      .any (any),
      .win (win)
   );

   logic [PTR_W-1:0] own_ptr, tgt_ptr, eff_ptr;
   logic [CH_W-1:0]  tgt;
   logic [LEN_W-1:0] win_rsv;
   logic             bad;

   always_comb begin
      own_ptr = '0;
      tgt     = '0;
      win_rsv = '0;
      for (int k = 0; k < N_CH; k++) begin
         if (win == CH_W'(k)) begin
            own_ptr = ptr[k];
            tgt     = link[k];
            win_rsv = rsv[k];
         end
      end
      tgt_ptr = '0;
      for (int k = 0; k < N_CH; k++) begin
         if (tgt == CH_W'(k)) tgt_ptr = ptr[k];
      end
      // one level only: a target that is itself a link is rejected
      if (own_ptr != '0) begin
         eff_ptr = own_ptr;
         bad     = 1'b0;
      end else if (tgt_ptr != '0) begin
         eff_ptr = tgt_ptr;
         bad     = 1'b0;
      end else begin
         eff_ptr = '0;
         bad     = 1'b1;
      end
   end

   // ---------------- result registers ----------------
   logic             armed;
   logic [LEN_W-1:0] rsv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_valid   <= 1'b0;
         hit_none    <= 1'b0;
         hit_chan    <= '0;
         hit_ptr     <= '0;
         hit_badlink <= 1'b0;
         armed       <= 1'b0;
         rsv_q       <= '0;
      end else begin
         hit_valid   <= id_done && any;
         hit_none    <= id_done && !any;
         hit_badlink <= id_done && any && bad;
         if (id_done) begin
            hit_chan <= any ? win : '0;
            hit_ptr  <= any ? eff_ptr : '0;
            armed    <= any;
            rsv_q    <= any ? win_rsv : '0;
         end else if (len_done) begin
            armed    <= 1'b0;
         end
      end
   end

   idflt_len #(.LEN_W(LEN_W)) u_len (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_done  (len_done),
      .armed     (armed),
      .rcv       (len_rcvd),
      .rsv       (rsv_q),
      .len_valid (len_valid),
      .len_report(len_report),
      .len_store (len_store),
      .crc_keep  (crc_keep)
   );
endmodule

// File: rtl/idflt_chk.sv
`timescale 1ns/1ps
module idflt_chk #(
   parameter int N_CH  = 14,
   parameter int PTR_W = 7,
   parameter int LEN_W = 5,
   parameter int CH_W  = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             id_done,
   input logic             hit_valid,
   input logic             hit_none,
   input logic [CH_W-1:0]  hit_chan,
   input logic [PTR_W-1:0] hit_ptr,
   input logic             hit_badlink,
   input logic             len_done,
   input logic             len_valid,
   input logic [LEN_W-1:0] len_report,
   input logic [LEN_W-1:0] len_store,
   input logic             crc_keep
);
   assert_one_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_valid && hit_none));
   assert_result_due_R5: assert property (@(posedge clk) disable iff (!rst_n)
      id_done |=> (hit_valid || hit_none));
   assert_result_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_valid || hit_none) |-> $past(id_done));
   assert_chan_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_valid |-> (int'(hit_chan) < N_CH));
   assert_badlink_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_badlink |-> (hit_valid && hit_ptr == '0));
   assert_len_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      len_valid |-> $past(len_done));
   assert_store_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      len_valid |-> (len_store <= len_report));
   assert_crc_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
      crc_keep |-> (len_valid && len_store == len_report));
endmodule

bind id_filter idflt_chk #(
   .N_CH(N_CH), .PTR_W(PTR_W), .LEN_W(LEN_W), .CH_W(CH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .id_done    (id_done),
   .hit_valid  (hit_valid),
   .hit_none   (hit_none),
   .hit_chan   (hit_chan),
   .hit_ptr    (hit_ptr),
   .hit_badlink(hit_badlink),
   .len_done   (len_done),
   .len_valid  (len_valid),
   .len_report (len_report),
   .len_store  (len_store),
   .crc_keep   (crc_keep)
);

// File: tb/sim_id_filter.sv
`timescale 1ns/1ps
module sim_id_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic        id_done = 1'b0;
   logic [11:0] id_in = 12'h000;
   logic        hit_valid, hit_none, hit_badlink;
   logic [3:0]  hit_chan;
   logic [6:0]  hit_ptr;
   logic        len_done = 1'b0;
   logic [4:0]  len_rcvd = 5'd0;
   logic        len_valid, crc_keep;
   logic [4:0]  len_report, len_store;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   id_filter u0 (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .id_done(id_done), .id_in(id_in),
      .hit_valid(hit_valid), .hit_none(hit_none), .hit_chan(hit_chan),
      .hit_ptr(hit_ptr), .hit_badlink(hit_badlink),
      .len_done(len_done), .len_rcvd(len_rcvd),
      .len_valid(len_valid), .len_report(len_report), .len_store(len_store),
      .crc_keep(crc_keep)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      reg_addr  = 8'(addr);
      reg_wdata = 8'(data);
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input int addr, output int data);
      @(negedge clk);
      reg_addr = 8'(addr);
      #1;
      data = int'(reg_rdata);
   endtask

   function automatic int ba(input int k);
      return 'h10 + 8 * k;
   endfunction

   task automatic cfg(input int k, input int tag, input int mask, input int ptr,
                      input int en, input int rsv, input int link);
      wr(ba(k) + 0, tag & 'hff);
      wr(ba(k) + 1, (tag >> 8) & 'hf);
      wr(ba(k) + 2, mask & 'hff);
      wr(ba(k) + 3, (mask >> 8) & 'hf);
      wr(ba(k) + 4, ptr);
      wr(ba(k) + 5, (en << 7) | rsv);
      wr(ba(k) + 6, 0);
      wr(ba(k) + 7, link);
   endtask

   task automatic clr(input int k);
      wr(ba(k) + 6, 0);
   endtask

   task automatic off(input int k);
      wr(ba(k) + 5, 0);
   endtask

   task automatic send_id(input int id, input string req, input int ev, input int ech,
                          input int eptr, input int ebad);
      @(negedge clk);
      id_in   = 12'(id);
      id_done = 1'b1;
      @(negedge clk);
      id_done = 1'b0;
      chk(req, int'(hit_valid), ev);
      chk(req, int'(hit_none), ev ? 0 : 1);
      if (ev != 0) begin
         chk(req, int'(hit_chan), ech);
         chk(req, int'(hit_ptr), eptr);
         chk(req, int'(hit_badlink), ebad);
      end
   endtask

   task automatic send_len(input int rcv, input string req, input int ev,
                           input int estore, input int ecrc);
      @(negedge clk);
      len_rcvd = 5'(rcv);
      len_done = 1'b1;
      @(negedge clk);
      len_done = 1'b0;
      chk(req, int'(len_valid), ev);
      chk(req, int'(len_report), ev ? rcv : 0);
      chk(req, int'(len_store), estore);
      chk(req, int'(crc_keep), ecrc);
   endtask

   task automatic t_reset;
      chk("R11 hit_valid", int'(hit_valid), 0);
      chk("R11 hit_none", int'(hit_none), 0);
      chk("R11 len_valid", int'(len_valid), 0);
      chk("R11 crc_keep", int'(crc_keep), 0);
   endtask

   task automatic t_readback;
      int d;
      cfg(3, 'hABC, 'h5F3, 'h41, 1, 9, 5);
      rd(ba(3) + 0, d); chk("R1 tag lo", d, 'hBC);
      rd(ba(3) + 1, d); chk("R1 tag hi", d, 'h0A);
      rd(ba(3) + 3, d); chk("R1 mask hi", d, 'h05);
      rd(ba(3) + 5, d); chk("R1 ctl", d, 'h89);
      rd(ba(3) + 7, d); chk("R1 link", d, 'h05);
      wr(ba(3) + 1, 'hFF);
      rd(ba(3) + 1, d); chk("R1 unused bits read 0", d, 'h0F);
      rd('h0F, d); chk("R1 below window", d, 0);
      rd(ba(13) + 4, d); chk("R1 last channel ptr", d, 14);
      wr(ba(3) + 6, 'hFF);
      rd(ba(3) + 6, d); chk("R6 write 1 does not set", d, 0);
      off(3);
   endtask

   task automatic t_mask;
      cfg(2, 'h5A0, 'hFF0, 'h20, 1, 4, 0);
      send_id('h5A7, "R2 masked low bits ignored", 1, 2, 'h20, 0);
      clr(2);
      send_id('h4A0, "R2 masked-in bit differs", 0, 0, 0, 0);
      send_id('h5B0, "R2 middle bit differs", 0, 0, 0, 0);
      off(2);
   endtask

   task automatic t_prio;
      int d;
      cfg(9, 'h123, 'hFFF, 'h30, 1, 6, 0);
      cfg(4, 'h123, 'hFFF, 'h10, 1, 6, 0);
      send_id('h123, "R3 lowest index wins", 1, 4, 'h10, 0);
      rd(ba(4) + 6, d); chk("R6 winner flag set", d, 1);
      send_id('h123, "R4 flagged channel skipped", 1, 9, 'h30, 0);
      send_id('h123, "R4 all flagged gives none", 0, 0, 0, 0);
      clr(4);
      rd(ba(4) + 6, d); chk("R6 write 0 clears", d, 0);
      send_id('h123, "R3 cleared channel wins again", 1, 4, 'h10, 0);
      clr(4); clr(9);
      off(4);
      send_id('h123, "R4 disabled channel skipped", 1, 9, 'h30, 0);
      clr(9);
   endtask

   task automatic t_link;
      cfg(6, 'h777, 'hFFF, 0, 1, 3, 9);
      send_id('h777, "R7 link resolved", 1, 6, 'h30, 0);
      clr(6);
      cfg(7, 0, 0, 0, 0, 0, 0);
      wr(ba(6) + 7, 7);
      send_id('h777, "R7 link to a link", 1, 6, 0, 1);
      clr(6);
      wr(ba(6) + 7, 15);
      send_id('h777, "R7 link out of range", 1, 6, 0, 1);
      clr(6);
      off(6);
   endtask

   task automatic t_len;
      cfg(1, 'h0C8, 'hFFF, 'h50, 1, 10, 0);
      send_id('h0C8, "R8 setup", 1, 1, 'h50, 0);
      send_len(5, "R9 room for crc", 1, 5, 1);
      clr(1);
      send_id('h0C8, "R8 setup", 1, 1, 'h50, 0);
      send_len(8, "R9 exactly two spare", 1, 8, 1);
      clr(1);
      send_id('h0C8, "R8 setup", 1, 1, 'h50, 0);
      send_len(9, "R9 one spare", 1, 9, 0);
      clr(1);
      send_id('h0C8, "R8 setup", 1, 1, 'h50, 0);
      send_len(12, "R8 longer than reserved", 1, 10, 0);
      send_len(4, "R10 already consumed", 0, 0, 0);
      clr(1);
      send_id('h0C9, "R10 setup no match", 0, 0, 0, 0);
      send_len(3, "R10 after no match", 0, 0, 0);
      off(1);
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      for (int k = 0; k < 14; k++) cfg(k, 0, 0, k + 1, 0, 0, 0);
      t_readback;
      t_mask;
      t_prio;
      t_link;
      t_len;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule